// File: doc/BRIEF.md
# Prescaled Programmable Baud Tick Generator

This block makes the single clock-enable that paces both the transmitter and the receiver of a serial port. No derived clocks are produced. The block first divides the free-running input clock by a selectable ratio of 1, 3, 6 or 12. It then counts those prescaled enables against a 16-bit divisor and emits a one-cycle tick at sixteen times the bit rate.

The divisor is loaded as two byte-wide halves. Each half has its own write strobe. Each byte write restarts both counting stages, and so does any change of the prescale select. A new rate therefore applies from the cycle after the update, and no partly counted old period is left to finish. A divisor of zero keeps the tick low.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescale select code picks the first-stage ratio: 2'b00 = divide by 1, 2'b01 = divide by 3, 2'b10 = divide by 6, 2'b11 = divide by 12.
- R2: With a divisor D in 1..65535 and a prescale ratio P, `tick16_o` repeats with a period of exactly D*P clock cycles.
- R3: The divisor is two byte latches: the low strobe loads bits 7:0 and the high strobe loads bits 15:8. A write to one byte leaves the other byte unchanged.
- R4: While the divisor is zero, `tick16_o` stays low.
- R5: When both stages divide by 1 (select 2'b00, divisor 1), `tick16_o` is high on every cycle.
- R6: A write to either divisor byte, or a change of the prescale select, restarts both stages at the clock edge where it is sampled. The first tick then appears D*P cycles after that edge.
- R7: Reset clears both divisor bytes to zero and the prescale select to divide by 1, and holds `tick16_o` low.
- R8: When the product D*P is greater than 1, each tick lasts one clock cycle, and ticks happen only in cycles where the prescaler has completed a count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_sel_i | input | 2 | Prescale ratio code (R1) |
| div_lo_we_i | input | 1 | Load strobe for the divisor low byte |
| div_lo_i | input | 8 | Divisor low byte data |
| div_hi_we_i | input | 1 | Load strobe for the divisor high byte |
| div_hi_i | input | 8 | Divisor high byte data |
| tick16_o | output | 1 | One-cycle enable at 16x the bit rate |

## Verification
The assertions check, on every cycle, the following properties:
- both counters stay inside their range;
- an unwritten byte holds its value;
- a restart clears the counters on the next cycle;
- ticks follow a prescaler completion;
- a zero divisor keeps the output silent;
- the unity setting ticks continuously.

Exact periods, the first-tick latency after a reconfiguration, and the combining of the two bytes into one divisor value can only be shown by the bench. The bench writes divisors, changes the select and counts cycles between ticks, including the extreme divisor 65535.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int PC_W = 4;

    typedef enum logic [1:0] {
        PS_DIV1  = 2'b00,
        PS_DIV3  = 2'b01,
        PS_DIV6  = 2'b10,
        PS_DIV12 = 2'b11
    } presc_sel_e;

    // Terminal count (ratio minus one) of the prescaler for a select code.
    function automatic logic [PC_W-1:0] presc_last(presc_sel_e sel);
        logic [PC_W-1:0] r;
        case (sel)
            PS_DIV1:  r = PC_W'(0);
            PS_DIV3:  r = PC_W'(2);
            PS_DIV6:  r = PC_W'(5);
            default:  r = PC_W'(11);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
    parameter int BYTE_W = 8,
    parameter int NB     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NB-1:0]              we_i,
    input  logic [NB-1:0][BYTE_W-1:0]  data_i,
    output logic [NB*BYTE_W-1:0]       div_o
);

    typedef struct packed {
        logic [NB-1:0][BYTE_W-1:0] lanes;
    } latch_t;

    latch_t st_d, st_q;
    logic [NB-1:0][BYTE_W-1:0] lane_d;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane_d[g] = we_i[g] ? data_i[g] : st_q.lanes[g];

        AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !we_i[g] |=> $stable(st_q.lanes[g])) else $error("lane changed without strobe"); // R3
    end

    always_comb begin
        st_d       = st_q;
        st_d.lanes = lane_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_o = st_q.lanes;

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  presc_sel_e sel_i,
    input  logic       restart_i,
    output logic       presc_en_o
);

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic [PC_W-1:0] last;

    assign last = presc_last(sel_i);

    always_comb begin
        st_d = st_q;
        if (restart_i)              st_d.cnt = '0;
        else if (st_q.cnt == last)  st_d.cnt = '0;
        else                        st_d.cnt = st_q.cnt + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign presc_en_o = (st_q.cnt == last);

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= presc_last(sel_i)) else $error("prescaler count out of range"); // R1
    AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> st_q.cnt == '0) else $error("prescaler not cleared"); // R6

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             presc_en_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } dv_t;

    dv_t st_d, st_q;
    logic at_end;
    logic div_zero;

    assign div_zero = (div_i == '0);
    assign at_end   = (st_q.cnt == div_i - DIV_W'(1));

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (presc_en_i) begin
            if (div_zero) begin
                st_d.cnt = '0;
            end else if (at_end) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !div_zero |-> st_q.cnt < div_i) else $error("divider count out of range"); // R2
    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.cnt == '0 && !st_q.tick)) else $error("divider not cleared"); // R6
    AST_TICK_ON_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> $past(presc_en_i)) else $error("tick without prescaler enable"); // R8

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        presc_sel_i,
    input  logic              div_lo_we_i,
    input  logic [BYTE_W-1:0] div_lo_i,
    input  logic              div_hi_we_i,
    input  logic [BYTE_W-1:0] div_hi_i,
    output logic              tick16_o
);

    localparam int NB    = 2;
    localparam int DIV_W = NB * BYTE_W;

    typedef struct packed {
        presc_sel_e sel;
    } top_t;

    top_t st_d, st_q;
    presc_sel_e sel_in;
    logic restart;
    logic presc_en;
    logic [NB-1:0] lane_we;
    logic [NB-1:0][BYTE_W-1:0] lane_data;
    logic [DIV_W-1:0] div;

    assign sel_in       = presc_sel_e'(presc_sel_i);
    assign lane_we      = {div_hi_we_i, div_lo_we_i};
    assign lane_data[0] = div_lo_i;
    assign lane_data[1] = div_hi_i;

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sel: PS_DIV1};
        else        st_q <= st_d;
    end

    assign restart = (|lane_we) || (sel_in != st_q.sel);

    baud_div_latch #(.BYTE_W(BYTE_W), .NB(NB)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (lane_we),
        .data_i (lane_data),
        .div_o  (div)
    );

    baud_prescaler u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (st_q.sel),
        .restart_i  (restart),
        .presc_en_o (presc_en)
    );

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .presc_en_i (presc_en),
        .restart_i  (restart),
        .div_i      (div),
        .tick_o     (tick16_o)
    );

    AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |=> !tick16_o) else $error("tick with zero divisor"); // R4
    AST_UNITY_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel == PS_DIV1 && div == DIV_W'(1) && !restart) |=> tick16_o)
        else $error("unity setting missed a tick"); // R5

endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] presc_sel = 2'b00;
    logic       lo_we = 1'b0, hi_we = 1'b0;
    logic [7:0] lo_d = '0, hi_d = '0;
    logic       tick;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .presc_sel_i(presc_sel),
        .div_lo_we_i(lo_we), .div_lo_i(lo_d),
        .div_hi_we_i(hi_we), .div_hi_i(hi_d),
        .tick16_o(tick)
    );

    function automatic int ratio_of(logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 3;
            2'b10: return 6;
            default: return 12;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive both bytes and the select; returns after the high-byte edge.
    task automatic configure(logic [1:0] s, int d);
        @(negedge clk);
        presc_sel = s; lo_we = 1'b1; lo_d = d[7:0];
        @(negedge clk);
        lo_we = 1'b0; hi_we = 1'b1; hi_d = d[15:8];
        @(posedge clk);
        #1 hi_we = 1'b0;
    endtask

    task automatic write_byte(bit hi, logic [7:0] v);
        @(negedge clk);
        if (hi) begin hi_we = 1'b1; hi_d = v; end
        else    begin lo_we = 1'b1; lo_d = v; end
        @(posedge clk);
        #1 lo_we = 1'b0; hi_we = 1'b0;
    endtask

    // Cycles from the last update edge to the next tick (0 if none within limit).
    task automatic wait_tick(int limit, output int lat);
        lat = 0;
        for (int k = 1; k <= limit; k++) begin
            @(posedge clk); #1;
            if (tick) begin lat = k; return; end
        end
    endtask

    task automatic measure(string req, int exp, int periods);
        int lat;
        wait_tick(exp + 4, lat);
        check({req, " first tick latency"}, lat, exp);
        for (int p = 0; p < periods; p++) begin
            if (exp > 1) begin
                @(posedge clk); #1;
                check("R8 tick width one cycle", int'(tick), 0);
                wait_tick(exp + 4, lat);
                check({req, " period"}, lat + 1, exp);
            end else begin
                wait_tick(2, lat);
                check({req, " period"}, lat, exp);
            end
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<190000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin : stim
        int lat, ones;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7: reset state, no tick with zero divisor
        ones = 0;
        for (int k = 0; k < 100; k++) begin @(posedge clk); #1; ones += int'(tick); end
        check("R7 silent after reset", ones, 0);

        // R7/R3: low byte only to 1; reset select /1 and high byte 0 -> every cycle
        write_byte(1'b0, 8'd1);
        ones = 0;
        for (int k = 0; k < 50; k++) begin @(posedge clk); #1; ones += int'(tick); end
        check("R7 reset select is divide-by-1", ones, 50);

        // R5: unity both stages
        configure(2'b00, 1);
        measure("R5", 1, 20);

        // R1: each select with divisor 5
        for (int s = 0; s < 4; s++) begin
            configure(2'(s), 5);
            measure("R1", 5 * ratio_of(2'(s)), 2);
        end

        // R3: byte lanes combine and hold independently
        configure(2'b00, 5);
        write_byte(1'b1, 8'h01);
        measure("R3 high byte only", 261, 1);
        write_byte(1'b0, 8'h02);
        measure("R3 low byte only", 258, 1);

        // R6: select change alone restarts from that edge
        configure(2'b00, 4);
        repeat (2) @(posedge clk);
        @(negedge clk); presc_sel = 2'b01;
        @(posedge clk); #1;
        measure("R6 select change", 12, 1);

        // R6: rewrite mid-period restarts the count
        configure(2'b11, 3);
        repeat (20) @(posedge clk);
        write_byte(1'b0, 8'd2);
        measure("R6 mid-period reload", 24, 1);

        // R4: zero divisor silences
        configure(2'b10, 0);
        ones = 0;
        for (int k = 0; k < 300; k++) begin @(posedge clk); #1; ones += int'(tick); end
        check("R4 zero divisor silent", ones, 0);

        // R2: constrained random
        for (int i = 0; i < 20; i++) begin
            logic [1:0] s;
            int d;
            s = 2'($urandom_range(3, 0));
            d = int'($urandom_range(60, 1));
            configure(s, d);
            measure("R2 random", d * ratio_of(s), 2);
        end

        // R2: maximum divisor
        configure(2'b00, 65535);
        wait_tick(65540, lat);
        check("R2 max divisor latency", lat, 65535);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule